// File: doc/BRIEF.md
# DDR2 Self-Refresh Entry and Exit Sequencer

This block sits on the controller side of a DDR2 memory interface. It puts the SDRAM into self refresh and later brings it back out. A host raises a one-cycle enter request. The sequencer then waits until every bank is precharged and the on-die termination is confirmed off. It issues the refresh command encoding in the same cycle that it pulls the clock-enable low, and it keeps the device in self refresh until the host asks to leave.

On exit, the sequencer first waits for the clock to be reported stable. It then raises clock-enable and drives only NOP during the short recovery window. Two ready flags open in turn: one for commands other than READ, and a later one, fixed at 200 cycles, for READ. ODT stays forced low until that later window has closed. A new enter request may arrive before the short window ends. It is held, and the device goes back into self refresh once the short window has passed, without waiting for the read window.

All timing limits are cycle counts set by parameters. Every output is a register.

Top module: `ddr2_sr_sequencer`

## Requirements
- R1: The command bus carries NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1) at all times, except for exactly one cycle of the refresh encoding (0,0,0,1). That cycle is the first cycle in which cke is low.
- R2: After an enter request, the refresh cycle is not issued while banks_idle is low. It appears in the cycle after the clock edge at which banks_idle and odt_off are both seen high.
- R3: From the cycle after an enter request until the read window closes, odt is low. Entry does not happen while odt_off is low.
- R4: cke stays low for at least T_CKE cycles. If the exit request has arrived by the refresh cycle and the clock is stable, cke rises exactly T_CKE+T_ISXR+2 cycles after the refresh cycle.
- R5: cke stays low until clk_stable has been seen high on T_ISXR consecutive edges during the exit wait. A drop restarts that count. cke rises exactly T_ISXR+1 cycles after clk_stable is raised.
- R6: While cke is high and nonread_ready is low, the command bus carries NOP.
- R7: nonread_ready rises exactly T_NR cycles after the cycle in which cke rises, where T_NR is the larger of T_XSNR and T_CKE.
- R8: read_ready rises exactly T_XSRD cycles after cke rises. Once both ready flags are high, odt follows host_odt one cycle later.
- R9: An enter request that arrives after cke rises is held pending. The next refresh cycle then comes exactly T_NR+2 cycles after the rise, and read_ready stays low in between.
- R10: An exit request is discarded unless the device is in the refresh cycle or in self refresh. The device then stays in self refresh.
- R11: After reset: cke high, NOP, nonread_ready and read_ready high, odt and sr_active low.
- R12: sr_active is high in exactly the cycles where cke is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Pulse: request self-refresh entry |
| exit_req | input | 1 | Pulse: request self-refresh exit |
| banks_idle | input | 1 | All banks precharged |
| odt_off | input | 1 | ODT disabled and its turn-off latency met |
| clk_stable | input | 1 | Memory clock is stable |
| host_odt | input | 1 | ODT value wanted by the host in normal operation |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| odt | output | 1 | On-die termination control |
| sr_active | output | 1 | Device is in self refresh (cke low) |
| nonread_ready | output | 1 | Commands other than READ allowed |
| read_ready | output | 1 | READ allowed |

## Verification
The hardest case to reach is early re-entry. An enter request must land inside the NOP-only recovery window, which opens only after a full entry, a minimum-length stay in self refresh and a clock-stable wait. The bench waits until it sees cke rise and pulses enter_req one cycle later. It then times the second refresh cycle against that rise and confirms that read_ready never rose in between. The restart of the clock-stable count is reached in a similar way: clk_stable is held low during an exit, raised for a single cycle, and then raised for good.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WAIT_IDLE  = 3'd1,
    ST_ENTER      = 3'd2,
    ST_IN_SR      = 3'd3,
    ST_CLK_WAIT   = 3'd4,
    ST_EXIT_NOP   = 3'd5,
    ST_NONREAD_OK = 3'd6,
    ST_READY      = 3'd7
  } sr_state_e;

  // Bus order: cs_n, ras_n, cas_n, we_n
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_NOP = 4'b0111;
  localparam ddr_cmd_t CMD_REF = 4'b0001;

endpackage

// File: rtl/sr_cycle_timer.sv
// Saturating up-counter used for every timing window of the sequencer.
module sr_cycle_timer #(
  parameter int W   = 8,
  parameter int SAT = 200
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LIMIT = W'(SAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && (count < LIMIT)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/sr_req_flag.sv
// Holds a single-cycle request until the sequencer consumes it.
module sr_req_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic arm,
  input  logic consume,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (consume) begin
      pend <= 1'b0;
    end else if (set && arm) begin
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/sr_out_decode.sv
// Maps a sequencer state to the values its outputs take in that state.
module sr_out_decode
  import sr_pkg::*;
(
  input  sr_state_e st,
  output logic      cke,
  output ddr_cmd_t  cmd,
  output logic      nonread,
  output logic      read,
  output logic      odt_allow,
  output logic      in_sr
);
  always_comb begin
    cke       = 1'b1;
    cmd       = CMD_NOP;
    nonread   = 1'b0;
    read      = 1'b0;
    odt_allow = 1'b0;
    in_sr     = 1'b0;
    unique case (st)
      ST_IDLE, ST_READY: begin
        nonread   = 1'b1;
        read      = 1'b1;
        odt_allow = 1'b1;
      end
      ST_WAIT_IDLE: begin
        cke = 1'b1;
      end
      ST_ENTER: begin
        cke   = 1'b0;
        cmd   = CMD_REF;
        in_sr = 1'b1;
      end
      ST_IN_SR, ST_CLK_WAIT: begin
        cke   = 1'b0;
        in_sr = 1'b1;
      end
      ST_EXIT_NOP: begin
        cke = 1'b1;
      end
      ST_NONREAD_OK: begin
        nonread = 1'b1;
      end
      default: begin
        cke = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ddr2_sr_sequencer.sv
module ddr2_sr_sequencer
  import sr_pkg::*;
#(
  parameter int T_CKE  = 3,
  parameter int T_XSNR = 36,
  parameter int T_ISXR = 2,
  parameter int T_XSRD = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic enter_req,
  input  logic exit_req,
  input  logic banks_idle,
  input  logic odt_off,
  input  logic clk_stable,
  input  logic host_odt,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic odt,
  output logic sr_active,
  output logic nonread_ready,
  output logic read_ready
);
  localparam int T_NR   = (T_XSNR > T_CKE) ? T_XSNR : T_CKE;
  localparam int T_MAX0 = (T_XSRD > T_NR) ? T_XSRD : T_NR;
  localparam int T_MAX  = (T_MAX0 > T_ISXR) ? T_MAX0 : T_ISXR;
  localparam int CW     = $clog2(T_MAX + 1) + 1;

  localparam logic [CW-1:0] K_CKE    = CW'(T_CKE);
  localparam logic [CW-1:0] K_ISXR   = CW'(T_ISXR);
  localparam logic [CW-1:0] K_NR_M1  = CW'(T_NR - 1);
  localparam logic [CW-1:0] K_XSRD_M1 = CW'(T_XSRD - 1);

  sr_state_e state_q, state_d;

  logic [CW-1:0] lo_cnt, stab_cnt, hi_cnt;
  logic          enter_pend, exit_pend;
  logic          take_enter, take_exit;
  logic          enter_arm, exit_arm;
  logic          lo_run, hi_run, in_clk_wait;

  assign lo_run      = (state_q == ST_ENTER) || (state_q == ST_IN_SR);
  assign hi_run      = (state_q == ST_EXIT_NOP) || (state_q == ST_NONREAD_OK);
  assign in_clk_wait = (state_q == ST_CLK_WAIT);

  // Enter requests are accepted everywhere except while already in self refresh.
  assign enter_arm = !lo_run && !in_clk_wait;
  // Exit requests only count from the refresh cycle on, until the exit starts.
  assign exit_arm  = lo_run;

  assign take_enter = enter_pend || enter_req;
  assign take_exit  = exit_pend  || (exit_req && exit_arm);

  // Cycles with cke low since entry
  sr_cycle_timer #(.W(CW), .SAT(T_CKE)) u_lo_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (!lo_run),
    .inc  (lo_run),
    .count(lo_cnt)
  );

  // Consecutive stable-clock samples during the exit wait
  sr_cycle_timer #(.W(CW), .SAT(T_ISXR)) u_stab_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (!in_clk_wait || !clk_stable),
    .inc  (in_clk_wait && clk_stable),
    .count(stab_cnt)
  );

  // Cycles since cke was raised on exit
  sr_cycle_timer #(.W(CW), .SAT(T_XSRD)) u_hi_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (!hi_run),
    .inc  (hi_run),
    .count(hi_cnt)
  );

  sr_req_flag u_enter_flag (
    .clk    (clk),
    .rst    (rst),
    .set    (enter_req),
    .arm    (enter_arm),
    .consume(state_d == ST_ENTER),
    .pend   (enter_pend)
  );

  sr_req_flag u_exit_flag (
    .clk    (clk),
    .rst    (rst),
    .set    (exit_req),
    .arm    (exit_arm),
    .consume(state_d == ST_CLK_WAIT),
    .pend   (exit_pend)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_READY: begin
        if (take_enter) state_d = ST_WAIT_IDLE;
      end
      ST_WAIT_IDLE: begin
        if (banks_idle && odt_off) state_d = ST_ENTER;
      end
      ST_ENTER: begin
        state_d = ST_IN_SR;
      end
      ST_IN_SR: begin
        if (take_exit && (lo_cnt >= K_CKE)) state_d = ST_CLK_WAIT;
      end
      ST_CLK_WAIT: begin
        if (clk_stable && (stab_cnt >= K_ISXR)) state_d = ST_EXIT_NOP;
      end
      ST_EXIT_NOP: begin
        if (hi_cnt >= K_NR_M1) state_d = ST_NONREAD_OK;
      end
      ST_NONREAD_OK: begin
        if (take_enter) begin
          state_d = ST_WAIT_IDLE;
        end else if (hi_cnt >= K_XSRD_M1) begin
          state_d = ST_READY;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  logic     dec_cke, dec_nonread, dec_read, dec_odt_allow, dec_in_sr;
  ddr_cmd_t dec_cmd;

  sr_out_decode u_decode (
    .st       (state_d),
    .cke      (dec_cke),
    .cmd      (dec_cmd),
    .nonread  (dec_nonread),
    .read     (dec_read),
    .odt_allow(dec_odt_allow),
    .in_sr    (dec_in_sr)
  );

  ddr_cmd_t cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke           <= 1'b1;
      cmd_q         <= CMD_NOP;
      nonread_ready <= 1'b1;
      read_ready    <= 1'b1;
      odt           <= 1'b0;
      sr_active     <= 1'b0;
    end else begin
      cke           <= dec_cke;
      cmd_q         <= dec_cmd;
      nonread_ready <= dec_nonread;
      read_ready    <= dec_read;
      odt           <= dec_odt_allow && host_odt;
      sr_active     <= dec_in_sr;
    end
  end

  assign cs_n  = cmd_q.cs_n;
  assign ras_n = cmd_q.ras_n;
  assign cas_n = cmd_q.cas_n;
  assign we_n  = cmd_q.we_n;

endmodule

// File: rtl/ddr2_sr_checker.sv
module ddr2_sr_checker #(
  parameter int T_CKE  = 3,
  parameter int T_XSNR = 36,
  parameter int T_XSRD = 200
) (
  input logic clk,
  input logic rst,
  input logic banks_idle,
  input logic odt_off,
  input logic clk_stable,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic odt,
  input logic sr_active,
  input logic nonread_ready,
  input logic read_ready
);
  localparam int T_NR = (T_XSNR > T_CKE) ? T_XSNR : T_CKE;
  localparam int HMAX = (T_XSRD > T_NR) ? T_XSRD : T_NR;
  localparam int CW   = $clog2(HMAX + 1) + 1;
  localparam logic [CW-1:0] HSAT = CW'(HMAX);
  localparam logic [CW-1:0] LSAT = CW'(T_CKE);

  logic [CW-1:0] hc, lc;
  logic is_nop, is_ref;

  assign is_nop = !cs_n &&  ras_n &&  cas_n &&  we_n;
  assign is_ref = !cs_n && !ras_n && !cas_n &&  we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      hc <= HSAT;
      lc <= '0;
    end else begin
      if (!cke)           hc <= '0;
      else if (hc < HSAT) hc <= hc + 1'b1;
      if (cke)            lc <= '0;
      else if (lc < LSAT) lc <= lc + 1'b1;
    end
  end

  p_bus_legal_r1: assert property (@(posedge clk) disable iff (rst)
    is_nop || is_ref);

  p_ref_with_cke_fall_r1: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> (!cke && $past(cke)));

  p_entry_needs_idle_r2: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> $past(banks_idle));

  p_entry_needs_odt_off_r3: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> $past(odt_off));

  p_cke_low_min_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (lc >= LSAT));

  p_stable_before_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> $past(clk_stable));

  p_nop_in_recovery_r6: assert property (@(posedge clk) disable iff (rst)
    (cke && !nonread_ready) |-> is_nop);

  p_nonread_window_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(nonread_ready) |-> (hc >= CW'(T_NR)));

  p_read_window_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(read_ready) |-> (hc >= CW'(T_XSRD)));

  p_odt_held_low_r8: assert property (@(posedge clk) disable iff (rst)
    !read_ready |-> !odt);

  p_reentry_gap_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> (hc >= CW'(T_NR)));

  p_active_tracks_cke_r12: assert property (@(posedge clk) disable iff (rst)
    sr_active != cke);

endmodule

bind ddr2_sr_sequencer ddr2_sr_checker #(
  .T_CKE (T_CKE),
  .T_XSNR(T_XSNR),
  .T_XSRD(T_XSRD)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .banks_idle   (banks_idle),
  .odt_off      (odt_off),
  .clk_stable   (clk_stable),
  .cke          (cke),
  .cs_n         (cs_n),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .odt          (odt),
  .sr_active    (sr_active),
  .nonread_ready(nonread_ready),
  .read_ready   (read_ready)
);

// File: tb/ddr2_sr_sequencer_test.sv
`timescale 1ns/1ps
module ddr2_sr_sequencer_test;
  localparam int T_CKE  = 3;
  localparam int T_XSNR = 12;
  localparam int T_ISXR = 2;
  localparam int T_XSRD = 200;
  localparam int T_NR   = (T_XSNR > T_CKE) ? T_XSNR : T_CKE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enter_req = 0, exit_req = 0, banks_idle = 0, odt_off = 0;
  logic clk_stable = 1, host_odt = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, odt, sr_active, nonread_ready, read_ready;

  always #4 clk = ~clk;

  ddr2_sr_sequencer #(
    .T_CKE(T_CKE), .T_XSNR(T_XSNR), .T_ISXR(T_ISXR), .T_XSRD(T_XSRD)
  ) uut (
    .clk(clk), .rst(rst), .enter_req(enter_req), .exit_req(exit_req),
    .banks_idle(banks_idle), .odt_off(odt_off), .clk_stable(clk_stable),
    .host_odt(host_odt), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .odt(odt), .sr_active(sr_active),
    .nonread_ready(nonread_ready), .read_ready(read_ready)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Cycle monitor, sampled on the falling edge
  int cyc = 0;
  int ref_cyc = 0, ref_n = 0;
  int rise_cyc = 0, rise_n = 0;
  int nr_cyc = 0, nr_n = 0;
  int rd_cyc = 0, rd_n = 0;
  bit prev_cke = 1, prev_nr = 1, prev_rd = 1;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0;
      prev_cke = 1; prev_nr = 1; prev_rd = 1;
    end else begin
      cyc++;
      if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) begin
        ref_cyc = cyc; ref_n++;
        check(!cke && prev_cke, "R1 refresh with cke falling", cke, 0);
      end else begin
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 nop on bus",
              {cs_n, ras_n, cas_n, we_n}, 7);
      end
      if (cke && !nonread_ready)
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R6 nop in recovery",
              {cs_n, ras_n, cas_n, we_n}, 7);
      if (!read_ready) check(odt == 1'b0, "R8 odt held low", odt, 0);
      check(sr_active == !cke, "R12 sr_active vs cke", sr_active, !cke);
      if (cke && !prev_cke)           begin rise_cyc = cyc; rise_n++; end
      if (nonread_ready && !prev_nr)  begin nr_cyc = cyc; nr_n++; end
      if (read_ready && !prev_rd)     begin rd_cyc = cyc; rd_n++; end
      prev_cke = cke; prev_nr = nonread_ready; prev_rd = read_ready;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_enter();
    enter_req = 1; step(1); enter_req = 0;
  endtask

  task automatic pulse_exit();
    exit_req = 1; step(1); exit_req = 0;
  endtask

  task automatic wait_ref(input int old_n);
    while (ref_n == old_n) step(1);
  endtask

  task automatic wait_rise(input int old_n);
    while (rise_n == old_n) step(1);
  endtask

  initial begin
    int n0, r0, k0, d0;
    step(3);
    rst = 0;
    step(1);
    // R11 reset state
    check(cke == 1, "R11 cke after reset", cke, 1);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R11 nop after reset",
          {cs_n, ras_n, cas_n, we_n}, 7);
    check(nonread_ready && read_ready, "R11 ready flags after reset",
          {nonread_ready, read_ready}, 3);
    check(!odt && !sr_active, "R11 odt and sr_active after reset",
          {odt, sr_active}, 0);

    // R8 odt pass-through in normal operation
    host_odt = 1; step(2);
    check(odt == 1, "R8 odt follows host", odt, 1);

    // R10 exit request while idle is discarded
    pulse_exit(); step(4);
    check(cke == 1 && ref_n == 0, "R10 exit ignored in idle", cke, 1);

    // R2/R3 entry held off by busy banks and active ODT
    pulse_enter();
    check(odt == 0, "R3 odt dropped after request", odt, 0);
    check(nonread_ready == 0, "R3 nonread closed while entering", nonread_ready, 0);
    pulse_exit();
    step(10);
    check(ref_n == 0 && cke == 1, "R2 no entry while banks busy", ref_n, 0);
    banks_idle = 1; step(6);
    check(ref_n == 0 && cke == 1, "R3 no entry while odt on", ref_n, 0);
    n0 = cyc; odt_off = 1;
    wait_ref(0);
    check(ref_cyc == n0 + 1, "R2 entry cycle", ref_cyc, n0 + 1);

    // R10 no exit without a request made in self refresh
    clk_stable = 0;
    step(40);
    check(cke == 0 && sr_active == 1, "R10 stays in self refresh", cke, 0);

    // R5 exit waits on clk_stable, blip restarts the count
    pulse_exit(); step(10);
    check(cke == 0, "R5 cke low while clock unstable", cke, 0);
    clk_stable = 1; step(1); clk_stable = 0; step(5);
    check(cke == 0 && rise_n == 0, "R5 blip restarts count", cke, 0);
    r0 = rise_n; n0 = cyc; clk_stable = 1;
    wait_rise(r0);
    check(rise_cyc == n0 + T_ISXR + 1, "R5 cke rise after stable", rise_cyc,
          n0 + T_ISXR + 1);
    k0 = nr_n; d0 = rd_n;
    while (rd_n == d0) step(1);
    check(nr_cyc - rise_cyc == T_NR, "R7 nonread window", nr_cyc - rise_cyc, T_NR);
    check(rd_cyc - rise_cyc == T_XSRD, "R8 read window", rd_cyc - rise_cyc, T_XSRD);
    check(nr_n == k0 + 1, "R7 single nonread rise", nr_n, k0 + 1);
    check(odt == 1, "R8 odt restored with read ready", odt, 1);

    // R4 early exit: request in the refresh cycle
    r0 = ref_n; pulse_enter(); wait_ref(r0);
    n0 = ref_cyc; k0 = rise_n;
    pulse_exit();
    wait_rise(k0);
    check(rise_cyc - n0 == T_CKE + T_ISXR + 2, "R4 minimum low time",
          rise_cyc - n0, T_CKE + T_ISXR + 2);

    // R9 re-entry request inside the recovery window
    n0 = rise_cyc; d0 = rd_n; r0 = ref_n;
    pulse_enter();
    wait_ref(r0);
    check(ref_cyc - n0 == T_NR + 2, "R9 re-entry timing", ref_cyc - n0, T_NR + 2);
    check(rd_n == d0, "R9 no read ready before re-entry", rd_n, d0);
    check(nr_cyc - n0 == T_NR, "R9 nonread opened before re-entry", nr_cyc - n0, T_NR);

    // leave again and finish normally
    k0 = rise_n; d0 = rd_n;
    pulse_exit(); wait_rise(k0);
    while (rd_n == d0) step(1);
    check(rd_cyc - rise_cyc == T_XSRD, "R8 read window second exit",
          rd_cyc - rise_cyc, T_XSRD);
    step(3);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule